// File: doc/BRIEF.md
# Single-precision to bfloat16 rounding converter

This block narrows a 32-bit IEEE single-precision word to the 16-bit bfloat16 format. It keeps the sign, the full 8-bit exponent and the top 7 fraction bits. The 16 bits that are dropped decide the rounding. If bit 15 of the input is set, the kept half is incremented, so an exact half rounds away from zero in magnitude. Rounding is an integer add of 0x8000 to the whole word, followed by clearing of the low 16 bits. A carry out of the fraction therefore moves into the exponent. The largest finite values can round up to the infinity pattern.

Two classes of input skip the add and only lose their low half: a signed zero, and any word whose exponent is all ones (infinity or NaN). The result comes out in two forms: as the 16-bit pattern, and as a 32-bit word with the pattern in the upper half and zeros below. The conversion logic is combinational. A parameter places an output register after it, which is on by default.

Top module: `fp2bf_conv`

## Requirements
- R1: When input bits 30:0 are all zero (positive or negative zero), `bf_out` equals input bits 31:16, so 0x80000000 gives 0x8000.
- R2: When the exponent field, input bits 30:23, equals 0xFF, `bf_out` equals input bits 31:16 with no rounding. For example, 0x7F80FFFF gives 0x7F80 and 0x7FFFFFFF gives 0x7FFF.
- R3: For every other input, `bf_out` equals bits 31:16 of (input + 0x00008000) taken as a 32-bit unsigned sum.
- R4: An exact half (low 16 bits equal to 0x8000) rounds up in magnitude, not to even. 0x3F808000 gives 0x3F81, 0x3F818000 gives 0x3F82 and 0xBF808000 gives 0xBF81.
- R5: When input bit 15 is zero on a rounded input, the low half is discarded with no change to the upper half. For example, 0x3F807FFF gives 0x3F80.
- R6: A carry out of the kept fraction raises the exponent by one. 0x3FFF8000 gives 0x4000, and 0x7F7F8000 and 0xFF7FC000 round to the infinity patterns 0x7F80 and 0xFF80. The sign bit of `bf_out` always equals input bit 31.
- R7: `wide_out` always equals {`bf_out`, 16'h0000}.
- R8: With `REGISTERED`=1, both outputs show the conversion of the input sampled at the previous rising clock edge. While `rst_n` is low, both outputs are zero.
- R9: Reference values: 0x3F99999A gives 0x3F9A and 0x4013D70A gives 0x4014.
- R10: A zero exponent with a non-zero fraction is rounded like any finite value. 0x00008000 gives 0x0001 and 0x007FFFFF gives 0x0080.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| fp_in | input | 32 | Single-precision input word |
| bf_out | output | 16 | bfloat16 result |
| wide_out | output | 32 | bfloat16 result in the upper half, low half zero |

## Verification
Two effects can occur on the same conversion: the rounding add and the carry that spills into the exponent field. In the extreme case they also produce an infinity from a finite value. Inputs whose kept fraction is all ones and whose bit 15 is set trigger this, including exponent 0xFE with both signs. These results are judged against values written by hand. The neighbouring case, where the exponent is already 0xFF, shows that the bypass wins and that no carry reaches the sign bit.

// File: rtl/fp2bf_pkg.sv
package fp2bf_pkg;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = WORD_W / 2;
  localparam int FRAC_W  = 23;
  localparam int EXP_W   = 8;
  localparam int EXP_LSB = FRAC_W;
  localparam int EXP_MSB = FRAC_W + EXP_W - 1;
  localparam int SIGN_B  = WORD_W - 1;

  typedef enum logic [1:0] {
    CLS_FINITE  = 2'd0,
    CLS_ZERO    = 2'd1,
    CLS_SPECIAL = 2'd2
  } in_class_e;

  localparam logic [WORD_W-1:0] HALF_ULP  = WORD_W'(1) << (HALF_W - 1);
  localparam logic [WORD_W-1:0] KEEP_MASK = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};

  function automatic in_class_e classify(input logic [WORD_W-1:0] w);
    if (&w[EXP_MSB:EXP_LSB])   return CLS_SPECIAL;
    if (w[SIGN_B-1:0] == '0)   return CLS_ZERO;
    return CLS_FINITE;
  endfunction

  function automatic logic [WORD_W-1:0] round_half_up(input logic [WORD_W-1:0] w);
    return w + HALF_ULP;
  endfunction

  function automatic logic [WORD_W-1:0] keep_upper(input logic [WORD_W-1:0] w);
    return w & KEEP_MASK;
  endfunction
endpackage

// File: rtl/fp2bf_classify.sv
module fp2bf_classify
  import fp2bf_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output in_class_e         cls_o,
  output logic              is_zero_o,
  output logic              is_special_o
);
  always_comb begin
    cls_o        = classify(word_i);
    is_zero_o    = (cls_o == CLS_ZERO);
    is_special_o = (cls_o == CLS_SPECIAL);
  end
endmodule

// File: rtl/fp2bf_round.sv
module fp2bf_round
  import fp2bf_pkg::*;
(
  input  logic              en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] rnd_o,
  output logic              exp_carry_o
);
  logic [WORD_W-1:0] sum;
  always_comb begin
    sum         = round_half_up(word_i);
    rnd_o       = en_i ? sum : word_i;
    exp_carry_o = en_i && (sum[EXP_MSB:EXP_LSB] != word_i[EXP_MSB:EXP_LSB]);
  end
endmodule

// File: rtl/fp2bf_outreg.sv
module fp2bf_outreg #(
  parameter bit REGISTERED = 1'b1,
  parameter int W          = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REGISTERED) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_wire
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/fp2bf_conv.sv
module fp2bf_conv
  import fp2bf_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fp_in,
  output logic [HALF_W-1:0] bf_out,
  output logic [WORD_W-1:0] wide_out
);
  in_class_e         cls;
  logic              is_zero;
  logic              is_special;
  logic              exp_carry;
  logic [WORD_W-1:0] rnd_word;
  logic [WORD_W-1:0] kept_word;
  logic [HALF_W-1:0] bf_next;

  fp2bf_classify u_cls (
    .word_i       (fp_in),
    .cls_o        (cls),
    .is_zero_o    (is_zero),
    .is_special_o (is_special)
  );

  fp2bf_round u_rnd (
    .en_i        (cls == CLS_FINITE),
    .word_i      (fp_in),
    .rnd_o       (rnd_word),
    .exp_carry_o (exp_carry)
  );

  assign kept_word = keep_upper(rnd_word);
  assign bf_next   = kept_word[WORD_W-1:HALF_W];

  fp2bf_outreg #(.REGISTERED(REGISTERED), .W(HALF_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (bf_next),
    .q_o   (bf_out)
  );

  assign wide_out = {bf_out, {HALF_W{1'b0}}};
endmodule

// File: rtl/fp2bf_conv_chk.sv
module fp2bf_conv_chk #(
  parameter bit REGISTERED = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] fp_in,
  input logic [15:0] bf_out,
  input logic [31:0] wide_out,
  input logic        is_zero,
  input logic        is_special,
  input logic        exp_carry,
  input logic [31:0] rnd_word
);
  logic [31:0] cap;
  logic        seen;
  logic [31:0] ref_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap  <= '0;
      seen <= 1'b0;
    end else begin
      cap  <= fp_in;
      seen <= 1'b1;
    end
  end

  assign ref_in = REGISTERED ? cap : fp_in;

  // R7
  wide_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wide_out == {bf_out, 16'h0000});

  // R1
  zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ref_in[30:0] == 31'd0) |-> bf_out == ref_in[31:16]);

  // R2
  special_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ref_in[30:23] == 8'hFF) |-> bf_out == ref_in[31:16]);

  // R5
  trunc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !ref_in[15]) |-> bf_out == ref_in[31:16]);

  // R6
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> bf_out[15] == ref_in[31]);

  // R6
  carry_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_carry |-> (rnd_word[30:23] == fp_in[30:23] + 8'd1 && rnd_word[22:16] == 7'd0));

  // R2
  bypass_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_special || is_zero) |-> (!exp_carry && rnd_word == fp_in));
endmodule

bind fp2bf_conv fp2bf_conv_chk #(.REGISTERED(REGISTERED)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fp_in      (fp_in),
  .bf_out     (bf_out),
  .wide_out   (wide_out),
  .is_zero    (is_zero),
  .is_special (is_special),
  .exp_carry  (exp_carry),
  .rnd_word   (rnd_word)
);

// File: tb/fp2bf_conv_bench.sv
module fp2bf_conv_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fp_in = '0;
  logic [15:0] bf_out;
  logic [31:0] wide_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp2bf_conv u_fp2bf_conv (
    .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .bf_out(bf_out), .wide_out(wide_out)
  );

  function automatic logic [15:0] expect_bf(input logic [31:0] w);
    logic [15:0] hi;
    hi = w[31:16];
    if (w[30:23] == 8'hFF) return hi;
    if (w[30:0] == 31'd0)  return hi;
    return w[15] ? hi + 16'd1 : hi;
  endfunction

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, register loads at next posedge, sample at following negedge
  task automatic convert(input string req, input logic [31:0] w, input logic [15:0] exp);
    @(negedge clk);
    fp_in = w;
    @(negedge clk);
    check16(req, bf_out, exp);
    check32("R7", wide_out, {exp, 16'h0000});
  endtask

  task automatic t_reset;
    check16("R8 reset bf", bf_out, 16'h0000);
    check32("R8 reset wide", wide_out, 32'h0);
  endtask

  task automatic t_reference;
    convert("R9", 32'h3F99999A, 16'h3F9A);
    convert("R9", 32'h4013D70A, 16'h4014);
  endtask

  task automatic t_zero;
    convert("R1", 32'h00000000, 16'h0000);
    convert("R1", 32'h80000000, 16'h8000);
  endtask

  task automatic t_special;
    convert("R2", 32'h7F80FFFF, 16'h7F80);
    convert("R2", 32'hFFC0C000, 16'hFFC0);
    convert("R2", 32'h7FFFFFFF, 16'h7FFF);
    convert("R2", 32'hFF808000, 16'hFF80);
  endtask

  task automatic t_ties;
    convert("R4", 32'h3F808000, 16'h3F81);
    convert("R4", 32'h3F818000, 16'h3F82);
    convert("R4", 32'hBF808000, 16'hBF81);
  endtask

  task automatic t_truncate;
    convert("R5", 32'h3F807FFF, 16'h3F80);
    convert("R5", 32'hC0490FDB, 16'hC049);
  endtask

  task automatic t_carry;
    convert("R6", 32'h3FFF8000, 16'h4000);
    convert("R6", 32'h7F7F8000, 16'h7F80);
    convert("R6", 32'hFF7FC000, 16'hFF80);
    convert("R6", 32'h7F7F7FFF, 16'h7F7F);
  endtask

  task automatic t_subnormal;
    convert("R10", 32'h00008000, 16'h0001);
    convert("R10", 32'h007FFFFF, 16'h0080);
    convert("R10", 32'h80007FFF, 16'h8000);
  endtask

  task automatic t_sweep;
    logic [31:0] s;
    s = 32'h1234ABCD;
    for (int i = 0; i < 300; i++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      convert("R3", s, expect_bf(s));
    end
  endtask

  task automatic t_latency;
    @(negedge clk);
    fp_in = 32'h40490FDB;
    @(negedge clk);
    fp_in = 32'h3F808000;
    #1;
    check16("R8 holds previous sample", bf_out, 16'h4049);
    @(negedge clk);
    check16("R8 one-cycle latency", bf_out, 16'h3F81);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    fp_in = 32'h3F99999A;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reference();
    t_zero();
    t_special();
    t_ties();
    t_truncate();
    t_carry();
    t_subnormal();
    t_sweep();
    t_latency();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule